// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two equal-width data ports, A and B, and passes data between them in either direction. A single active-low output enable together with a direction input decides which port, if any, the block drives. The driven port shows either the live value on the opposite port or the contents of a storage register that holds a copy of the opposite port. Each direction chooses its source on its own, and the choice can change from one cycle to the next.

There are two storage registers. The A-side register copies port A and the B-side register copies port B. Each register has its own capture enable, sampled on the rising edge of the block clock. The output enable, the direction input and the source selects do not gate capture. A register can therefore take in its port while the block drives that port, drives the other one, or drives neither. Each tristate pin group is split into a resolved input vector, an output vector and a drive-enable bit. A bus wrapper outside the block resolves the pins.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, both storage registers become zero after that edge.
- R2: While `oe_n` is 1, `a_oe` and `b_oe` are both 0, whatever the values of `dir_a2b` and the source selects.
- R3: While `oe_n` is 0, `dir_a2b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir_a2b` = 0 gives `a_oe` = 1 and `b_oe` = 0. The two enables are never 1 together.
- R4: While B is driven and `sel_a2b_store` is 0, `b_out` equals `a_in` in the same cycle.
- R5: While B is driven and `sel_a2b_store` is 1, `b_out` equals the A-side register.
- R6: While A is driven, `a_out` equals `b_in` when `sel_b2a_store` is 0 and equals the B-side register when it is 1.
- R7: At a rising edge with `cap_a` = 1, the A-side register loads `a_in`. At a rising edge with `cap_b` = 1, the B-side register loads `b_in`. With the capture input at 0, the register keeps its value.
- R8: Capture works the same for every value of `oe_n`, `dir_a2b` and the source selects, including while neither port is driven and while the block drives the port being captured.
- R9: In stored mode, a value captured at an edge shows on the driven port directly after that edge, with no extra cycle of delay.
- R10: Passing live data from one port to the other leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; captures happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of both registers |
| oe_n | input | 1 | Active-low output enable for both ports |
| dir_a2b | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_a2b_store | input | 1 | Source for B: 0 live A, 1 A-side register |
| sel_b2a_store | input | 1 | Source for A: 0 live B, 1 B-side register |
| cap_a | input | 1 | Load the A-side register from `a_in` at the next edge |
| cap_b | input | 1 | Load the B-side register from `b_in` at the next edge |
| a_in | input | W | Resolved value of the A pins |
| a_out | output | W | Value offered to the A pins |
| a_oe | output | 1 | Block drives the A pins |
| b_in | input | W | Resolved value of the B pins |
| b_out | output | W | Value offered to the B pins |
| b_oe | output | 1 | Block drives the B pins |

## Verification
The bench runs all sixteen combinations of enable, direction and the two selects. A decode error would show up here as both enables high, or as the wrong port driven. It captures while both ports are released. A design that gated capture with the enable would then keep the old register value. It captures with stored mode already selected and samples just after the edge, so a registered output stage would still show the previous value. It also moves live data through the block with capture off, changes the pins and then reads the registers back through stored mode. This check catches any write on the pass-through path.

// File: rtl/xcvr_pkg.sv
// Shared types for the registered bidirectional transceiver.
// Assumes: none; pure type definitions.
package xcvr_pkg;

    // Which port the block currently drives.
    typedef enum logic [1:0] {
        DRV_NONE = 2'b00,
        DRV_A    = 2'b01,
        DRV_B    = 2'b10
    } drive_mode_e;

endpackage

// File: rtl/xcvr_decode.sv
// Enable and direction decode.
// Turns the active-low enable and the direction bit into one drive mode
// and two mutually exclusive port enables.
// Assumes: inputs are stable within the cycle; purely combinational.
module xcvr_decode
    import xcvr_pkg::*;
(
    input  logic oe_n,
    input  logic dir_a2b,
    output logic drive_a,
    output logic drive_b
);

    drive_mode_e mode;

    // Purpose: choose which port, if any, is driven.
    always_comb begin
        if (oe_n)
            mode = DRV_NONE;
        else if (dir_a2b)
            mode = DRV_B;
        else
            mode = DRV_A;
    end

    // Purpose: expand the mode into per-port enables.
    always_comb begin
        drive_a = (mode == DRV_A);
        drive_b = (mode == DRV_B);
    end

endmodule

// File: rtl/xcvr_store.sv
// One storage register for one direction.
// Loads the resolved port value on a rising edge when cap is high.
// Otherwise it holds. Clears on synchronous active-low reset.
// Assumes: d is the resolved pin value, already settled at the edge.
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Purpose: capture or hold the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (cap)
            q <= d;
    end

    // R1: a reset edge leaves the register cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R7: an enabled edge loads the port value
    p_capture_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (q == $past(d)));

    // R7: without capture the register holds
    p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(q));

endmodule

// File: rtl/xcvr_route_mux.sv
// Output source select for one direction.
// Chooses between the live opposite-port value and the stored copy.
// Assumes: combinational; the result goes straight to the port output
// with no register, so a new capture shows after its edge.
module xcvr_route_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    input  logic         use_stored,
    output logic [W-1:0] y
);

    // Purpose: per-bit select between live and stored data.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = use_stored ? stored[i] : live[i];
    end

endmodule

// File: rtl/bidir_reg_xcvr.sv
// Registered bidirectional bus transceiver, top level.
// Two storage registers, one per port, each with its own capture enable.
// Capture is not gated by enable, direction or source select.
// Two output selects and an enable/direction decode complete the block.
// Assumes: the tristate pins are resolved outside; a_in and b_in carry the
// resolved pin values, including the block's own drive.
module bidir_reg_xcvr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir_a2b,
    input  logic         sel_a2b_store,
    input  logic         sel_b2a_store,
    input  logic         cap_a,
    input  logic         cap_b,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] qa;
    logic [W-1:0] qb;
    logic         drive_a;
    logic         drive_b;

    xcvr_decode u_dec (
        .oe_n    (oe_n),
        .dir_a2b (dir_a2b),
        .drive_a (drive_a),
        .drive_b (drive_b)
    );

    xcvr_store #(.W(W)) u_store_a (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap_a),
        .d     (a_in),
        .q     (qa)
    );

    xcvr_store #(.W(W)) u_store_b (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap_b),
        .d     (b_in),
        .q     (qb)
    );

    xcvr_route_mux #(.W(W)) u_to_b (
        .live       (a_in),
        .stored     (qa),
        .use_stored (sel_a2b_store),
        .y          (b_out)
    );

    xcvr_route_mux #(.W(W)) u_to_a (
        .live       (b_in),
        .stored     (qb),
        .use_stored (sel_b2a_store),
        .y          (a_out)
    );

    // Purpose: hand the decoded enables to the pin wrapper.
    assign a_oe = drive_a;
    assign b_oe = drive_b;

    // R2: disabled block releases both ports
    p_release_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!a_oe && !b_oe));

    // R3: enabled block drives exactly the port chosen by direction
    p_dir_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (b_oe == dir_a2b) && (a_oe == !dir_a2b));

    // R5: stored mode on B shows the A-side register
    p_b_stored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && sel_a2b_store) |-> (b_out == qa));

    // R9: a capture shows on B right after its edge
    p_no_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_a && !oe_n && dir_a2b) ##1 (b_oe && sel_a2b_store)
        |-> (b_out == $past(a_in)));

    // R10: live pass-through with no capture keeps both registers
    p_live_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_oe || b_oe) && !cap_a && !cap_b) |=> ($stable(qa) && $stable(qb)));

endmodule

// File: tb/tb_bidir_reg_xcvr.sv
// Directed bench for the registered bidirectional transceiver.
// Contains a simple bus wrapper: each pin group resolves to the block's
// output when the block drives it, and to the external driver otherwise.
module tb_bidir_reg_xcvr;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         oe_n, dir_a2b, sel_a2b_store, sel_b2a_store, cap_a, cap_b;
    logic [W-1:0] ext_a, ext_b;
    logic [W-1:0] a_in, a_out, b_in, b_out;
    logic         a_oe, b_oe;

    int n_checks = 0;
    int n_fails  = 0;

    logic [W-1:0] qa_m, qb_m;

    always #2 clk = ~clk;

    // Bus wrapper.
    assign a_in = a_oe ? a_out : ext_a;
    assign b_in = b_oe ? b_out : ext_b;

    bidir_reg_xcvr #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir_a2b(dir_a2b),
        .sel_a2b_store(sel_a2b_store), .sel_b2a_store(sel_b2a_store),
        .cap_a(cap_a), .cap_b(cap_b),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_ctl(input logic oe, input logic dir, input logic sa, input logic sb);
        @(negedge clk);
        oe_n = oe; dir_a2b = dir; sel_a2b_store = sa; sel_b2a_store = sb;
        #1;
    endtask

    // Read both registers through stored mode (B shows QA, A shows QB).
    task automatic read_regs(input string tag);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        chk({tag, " QA via B"}, b_out, qa_m);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        chk({tag, " QB via A"}, a_out, qb_m);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1; rst_n = 1'b1;
        qa_m = '0; qb_m = '0;
        read_regs("R1 reset");
    endtask

    task automatic t_all_modes;
        ext_a = 8'h5A; ext_b = 8'hC3;
        for (int k = 0; k < 16; k++) begin
            set_ctl(k[3], k[2], k[1], k[0]);
            if (k[3]) begin
                chk("R2 a_oe released", {7'd0, a_oe}, 8'd0);
                chk("R2 b_oe released", {7'd0, b_oe}, 8'd0);
            end else if (k[2]) begin
                chk("R3 b_oe on", {7'd0, b_oe}, 8'd1);
                chk("R3 a_oe off", {7'd0, a_oe}, 8'd0);
                chk(k[1] ? "R5 B stored" : "R4 B live", b_out, k[1] ? qa_m : ext_a);
            end else begin
                chk("R3 a_oe on", {7'd0, a_oe}, 8'd1);
                chk("R3 b_oe off", {7'd0, b_oe}, 8'd0);
                chk("R6 A source", a_out, k[0] ? qb_m : ext_b);
            end
        end
    endtask

    task automatic t_capture_released;
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        ext_a = 8'h3C; ext_b = 8'hE1;
        cap_a = 1'b1; cap_b = 1'b1;
        @(posedge clk); #1;
        cap_a = 1'b0; cap_b = 1'b0;
        qa_m = 8'h3C; qb_m = 8'hE1;
        read_regs("R8 R7 capture while released");
    endtask

    task automatic t_hold_and_live;
        // R10: live both ways, pins change, capture off
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'h11; #1;
        chk("R4 live new", b_out, 8'h11);
        repeat (2) @(posedge clk);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        ext_b = 8'h22; #1;
        chk("R6 live new", a_out, 8'h22);
        repeat (2) @(posedge clk);
        read_regs("R10 R7 hold after live");
    endtask

    task automatic t_no_latency;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        ext_a = 8'h96; cap_a = 1'b1;
        #0.5;
        chk("R9 before edge", b_out, qa_m);
        @(posedge clk); #1;
        cap_a = 1'b0; qa_m = 8'h96;
        chk("R9 right after edge", b_out, 8'h96);
    endtask

    task automatic t_capture_driven;
        // R8: B driven live from A; B-side register captures the driven pins
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        ext_a = 8'h4D; ext_b = 8'hFF; cap_b = 1'b1;
        @(posedge clk); #1;
        cap_b = 1'b0; qb_m = 8'h4D;
        read_regs("R8 capture driven port");
    endtask

    initial begin
        rst_n = 1'b1; oe_n = 1'b1; dir_a2b = 1'b0;
        sel_a2b_store = 1'b0; sel_b2a_store = 1'b0;
        cap_a = 1'b0; cap_b = 1'b0; ext_a = '0; ext_b = '0;
        qa_m = '0; qb_m = '0;
        t_reset();
        t_all_modes();
        t_capture_released();
        t_all_modes();
        t_hold_and_live();
        t_no_latency();
        t_capture_driven();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule